// File: doc/BRIEF.md
# YCbCr Output Formatter

This block sits at the end of a video decoder pipeline and turns one decoded luma sample and one Cb/Cr pair per pixel clock into an 8-bit Y bus and an 8-bit C bus. A line-valid strobe marks the active pixels of each line. On its rising edge a new chroma group starts, so the first active pixel of every line begins a fresh 4:2:2 pair or 4:1:1 quad. Incoming chroma is not filtered. The block keeps the Cb/Cr sample taken at the first pixel of each pair or quad and drops the rest.

Static configuration inputs control the output. They select 4:2:2 or 4:1:1 chroma packing and offset-binary or two's-complement chroma. They turn on separate range limiters for luma and chroma. They select a fixed blue picture that replaces the video while sync lock is missing, and they drive an output-enable flag for external tri-state drivers. Two 2-bit phase codes move the Y bus and the C bus in time, independently, by whole clocks around a nominal two-clock latency.

Top module: `ycc_out_fmt`

## Requirements
- R1: With `cfg_fmt411`=0, group position 0, 2, ... (even) puts the current pixel's Cb on the C bus, and the odd position that follows puts the Cr captured at that even pixel.
- R2: With `cfg_fmt411`=1, a group is four pixels. Position p (0..3) puts {Cb[7-2p:6-2p], Cr[7-2p:6-2p], 4'b0000} on the C bus, where Cb and Cr are the values captured at position 0.
- R3: With `cfg_c_twos`=1, bit 7 of Cb and of Cr is inverted before packing. Luma is never changed by this setting.
- R4: With `cfg_y_lim`=1, luma is clamped to 16..235. With `cfg_c_lim`=1, Cb and Cr are each clamped to 16..224. The clamp is applied before the two's-complement conversion. With a limiter off, its samples pass unchanged.
- R5: While `cfg_blue_en`=1 and `sync_lock`=0, the input samples are replaced by Y=41, Cb=240, Cr=110. The replacement values then go through limiting, conversion and packing like any other sample. With `cfg_blue_en`=0 the video passes through whatever the lock state.
- R6: The group position returns to 0 on the first pixel of each `line_vld` high period. It advances by one, wrapping, on each pixel with `line_vld` high.
- R7: With phase code 0, a sample driven on a clock edge appears on its bus after the next edge (two-clock latency).
- R8: Phase code 1 gives one clock, 2 gives four clocks, and 3 gives three clocks of latency. The Y code and the C code act independently.
- R9: `out_en` equals `cfg_out_en` in the same cycle.
- R10: During and after reset, before any new sample has reached the selected tap, `y_out` and `c_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_in | input | 8 | Decoded luma sample |
| cb_in | input | 8 | Decoded Cb sample, offset binary |
| cr_in | input | 8 | Decoded Cr sample, offset binary |
| line_vld | input | 1 | High on active pixels of a line |
| cfg_fmt411 | input | 1 | 1 selects 4:1:1 packing, 0 selects 4:2:2 |
| cfg_c_twos | input | 1 | 1 selects two's-complement chroma |
| cfg_y_lim | input | 1 | Luma limiter enable |
| cfg_c_lim | input | 1 | Chroma limiter enable |
| cfg_blue_en | input | 1 | Blue-screen-on-lost-sync enable |
| sync_lock | input | 1 | Sync lock indication from the decoder |
| cfg_out_en | input | 1 | Output driver enable request |
| cfg_y_phase | input | 2 | Y bus phase code |
| cfg_c_phase | input | 2 | C bus phase code |
| y_out | output | 8 | Luma output bus |
| c_out | output | 8 | Chroma output bus |
| out_en | output | 1 | Enable for external bus drivers |

## Verification
The assertions check the following on every cycle:
- the limiter ranges on the conditioned samples;
- the blue luma substitution;
- the zero low nibble of every 4:1:1 byte;
- the return of the group position after each line start;
- the exact two-clock latency of both buses at phase code 0.

The bench scenarios are needed for the rest. They check the full Cb/Cr ordering of the 4:2:2 and 4:1:1 packing across lines of odd and short lengths. They also check the interaction of blue screen with limiting and two's-complement conversion, and the other three phase codes, for which the bench compares outputs against its own model of the pixel stream.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned GRP_411 = 4;
  localparam int unsigned PH_W    = $clog2(GRP_411);
  localparam int unsigned TAP_MAX = 4;

  typedef logic [PIX_W-1:0] pix_t;

  // Saturate a sample into [lo, hi].
  function automatic pix_t clamp_pix(pix_t v, pix_t lo, pix_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Offset binary to two's complement: flip the sign bit.
  function automatic pix_t to_twos(pix_t v);
    return {~v[PIX_W-1], v[PIX_W-2:0]};
  endfunction

  // Phase code to pipeline stage: 0 nominal, 1 early, 2 two late, 3 one late.
  function automatic int unsigned tap_of(logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 1;
      2'd2:    return 4;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/ycc_sample_cond.sv
module ycc_sample_cond
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned Y_MIN   = 16,
  parameter int unsigned Y_MAX   = 235,
  parameter int unsigned C_MIN   = 16,
  parameter int unsigned C_MAX   = 224,
  parameter int unsigned BLUE_Y  = 41,
  parameter int unsigned BLUE_CB = 240,
  parameter int unsigned BLUE_CR = 110
) (
  input  pix_t y_in,
  input  pix_t cb_in,
  input  pix_t cr_in,
  input  logic blue_act,
  input  logic y_lim_en,
  input  logic c_lim_en,
  input  logic c_twos,
  output pix_t y_o,
  output pix_t cb_lim_o,
  output pix_t cr_lim_o,
  output pix_t cb_o,
  output pix_t cr_o
);
  pix_t y_src, cb_src, cr_src;

  always_comb begin
    y_src  = blue_act ? pix_t'(BLUE_Y)  : y_in;
    cb_src = blue_act ? pix_t'(BLUE_CB) : cb_in;
    cr_src = blue_act ? pix_t'(BLUE_CR) : cr_in;

    y_o      = y_lim_en ? clamp_pix(y_src,  pix_t'(Y_MIN), pix_t'(Y_MAX)) : y_src;
    cb_lim_o = c_lim_en ? clamp_pix(cb_src, pix_t'(C_MIN), pix_t'(C_MAX)) : cb_src;
    cr_lim_o = c_lim_en ? clamp_pix(cr_src, pix_t'(C_MIN), pix_t'(C_MAX)) : cr_src;

    cb_o = c_twos ? to_twos(cb_lim_o) : cb_lim_o;
    cr_o = c_twos ? to_twos(cr_lim_o) : cr_lim_o;
  end
endmodule

// File: rtl/ycc_chroma_pack.sv
module ycc_chroma_pack
  import ycc_fmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_vld,
  input  logic            fmt411,
  input  pix_t            cb_in,
  input  pix_t            cr_in,
  output pix_t            c_o,
  output logic            grp_start,
  output logic [PH_W-1:0] grp_ph
);
  logic            lv_q;
  logic [PH_W-1:0] cnt_q;
  pix_t            hold_cb, hold_cr;
  logic            capture;
  pix_t            cb_src, cr_src, cb_sh, cr_sh;

  always_comb begin
    grp_start = line_vld & ~lv_q;
    grp_ph    = grp_start ? '0 : cnt_q;
    capture   = fmt411 ? (grp_ph == '0) : ~grp_ph[0];
    cb_src    = capture ? cb_in : hold_cb;
    cr_src    = capture ? cr_in : hold_cr;
    cb_sh     = cb_src >> (PIX_W - 2 - 2 * int'(grp_ph));
    cr_sh     = cr_src >> (PIX_W - 2 - 2 * int'(grp_ph));
    if (fmt411) c_o = {cb_sh[1:0], cr_sh[1:0], {(PIX_W-4){1'b0}}};
    else        c_o = grp_ph[0] ? cr_src : cb_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q    <= 1'b0;
      cnt_q   <= '0;
      hold_cb <= '0;
      hold_cr <= '0;
    end else begin
      lv_q <= line_vld;
      if (line_vld) cnt_q <= grp_ph + PH_W'(1);
      if (capture) begin
        hold_cb <= cb_in;
        hold_cr <= cr_in;
      end
    end
  end
endmodule

// File: rtl/ycc_phase_line.sv
module ycc_phase_line
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned DEPTH = TAP_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pix_t       din,
  input  logic [1:0] code,
  output pix_t       dout
);
  pix_t taps [0:DEPTH];

  assign taps[0] = din;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    pix_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= taps[g-1];
    end
    assign taps[g] = q;
  end

  assign dout = taps[tap_of(code)];
endmodule

// File: rtl/ycc_out_fmt.sv
module ycc_out_fmt
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned Y_MIN   = 16,
  parameter int unsigned Y_MAX   = 235,
  parameter int unsigned C_MIN   = 16,
  parameter int unsigned C_MAX   = 224,
  parameter int unsigned BLUE_Y  = 41,
  parameter int unsigned BLUE_CB = 240,
  parameter int unsigned BLUE_CR = 110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] luma_in,
  input  logic [PIX_W-1:0] cb_in,
  input  logic [PIX_W-1:0] cr_in,
  input  logic             line_vld,
  input  logic             cfg_fmt411,
  input  logic             cfg_c_twos,
  input  logic             cfg_y_lim,
  input  logic             cfg_c_lim,
  input  logic             cfg_blue_en,
  input  logic             sync_lock,
  input  logic             cfg_out_en,
  input  logic [1:0]       cfg_y_phase,
  input  logic [1:0]       cfg_c_phase,
  output logic [PIX_W-1:0] y_out,
  output logic [PIX_W-1:0] c_out,
  output logic             out_en
);
  // Named internal events, used by the bound checker.
  logic            blue_act;
  pix_t            y_cond, cb_lim, cr_lim, cb_fin, cr_fin, c_pack;
  logic            grp_start;
  logic [PH_W-1:0] grp_ph;

  assign blue_act = cfg_blue_en & ~sync_lock;

  ycc_sample_cond #(
    .Y_MIN(Y_MIN), .Y_MAX(Y_MAX), .C_MIN(C_MIN), .C_MAX(C_MAX),
    .BLUE_Y(BLUE_Y), .BLUE_CB(BLUE_CB), .BLUE_CR(BLUE_CR)
  ) u_cond (
    .y_in(luma_in), .cb_in(cb_in), .cr_in(cr_in),
    .blue_act(blue_act), .y_lim_en(cfg_y_lim), .c_lim_en(cfg_c_lim),
    .c_twos(cfg_c_twos),
    .y_o(y_cond), .cb_lim_o(cb_lim), .cr_lim_o(cr_lim),
    .cb_o(cb_fin), .cr_o(cr_fin)
  );

  ycc_chroma_pack u_pack (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .fmt411(cfg_fmt411),
    .cb_in(cb_fin), .cr_in(cr_fin),
    .c_o(c_pack), .grp_start(grp_start), .grp_ph(grp_ph)
  );

  ycc_phase_line #(.DEPTH(TAP_MAX)) u_y_line (
    .clk(clk), .rst_n(rst_n), .din(y_cond), .code(cfg_y_phase), .dout(y_out)
  );

  ycc_phase_line #(.DEPTH(TAP_MAX)) u_c_line (
    .clk(clk), .rst_n(rst_n), .din(c_pack), .code(cfg_c_phase), .dout(c_out)
  );

  assign out_en = cfg_out_en;
endmodule

// File: rtl/ycc_out_fmt_chk.sv
module ycc_out_fmt_chk
  import ycc_fmt_pkg::*;
#(
  parameter int unsigned Y_MIN  = 16,
  parameter int unsigned Y_MAX  = 235,
  parameter int unsigned C_MIN  = 16,
  parameter int unsigned C_MAX  = 224,
  parameter int unsigned BLUE_Y = 41
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_fmt411,
  input logic            cfg_y_lim,
  input logic            cfg_c_lim,
  input logic            cfg_blue_en,
  input logic            sync_lock,
  input logic [1:0]      cfg_y_phase,
  input logic [1:0]      cfg_c_phase,
  input pix_t            y_cond,
  input pix_t            cb_lim,
  input pix_t            cr_lim,
  input pix_t            c_pack,
  input logic            grp_start,
  input logic [PH_W-1:0] grp_ph,
  input pix_t            y_out,
  input pix_t            c_out
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_y_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_y_lim |-> (y_cond >= pix_t'(Y_MIN) && y_cond <= pix_t'(Y_MAX)));

  p_c_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_c_lim |-> (cb_lim >= pix_t'(C_MIN) && cb_lim <= pix_t'(C_MAX) &&
                   cr_lim >= pix_t'(C_MIN) && cr_lim <= pix_t'(C_MAX)));

  p_blue_luma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_blue_en && !sync_lock && !cfg_y_lim) |-> y_cond == pix_t'(BLUE_Y));

  p_pad_411_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fmt411 |-> c_pack[3:0] == 4'b0000);

  p_grp_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_start |=> grp_ph == PH_W'(1));

  p_y_nominal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && cfg_y_phase == 2'd0) |-> y_out == $past(y_cond, 2));

  p_c_nominal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && cfg_c_phase == 2'd0) |-> c_out == $past(c_pack, 2));
endmodule

bind ycc_out_fmt ycc_out_fmt_chk #(
  .Y_MIN(Y_MIN), .Y_MAX(Y_MAX), .C_MIN(C_MIN), .C_MAX(C_MAX), .BLUE_Y(BLUE_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fmt411(cfg_fmt411), .cfg_y_lim(cfg_y_lim),
  .cfg_c_lim(cfg_c_lim), .cfg_blue_en(cfg_blue_en), .sync_lock(sync_lock),
  .cfg_y_phase(cfg_y_phase), .cfg_c_phase(cfg_c_phase),
  .y_cond(y_cond), .cb_lim(cb_lim), .cr_lim(cr_lim), .c_pack(c_pack),
  .grp_start(grp_start), .grp_ph(grp_ph), .y_out(y_out), .c_out(c_out)
);

// File: tb/ycc_out_fmt_tb.sv
module ycc_out_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] luma_in = '0, cb_in = '0, cr_in = '0;
  logic       line_vld = 1'b0;
  logic       cfg_fmt411 = 1'b0, cfg_c_twos = 1'b0, cfg_y_lim = 1'b0, cfg_c_lim = 1'b0;
  logic       cfg_blue_en = 1'b1, sync_lock = 1'b1, cfg_out_en = 1'b1;
  logic [1:0] cfg_y_phase = 2'd0, cfg_c_phase = 2'd0;
  logic [7:0] y_out, c_out;
  logic       out_en;

  always #5 clk = ~clk;

  ycc_out_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .luma_in(luma_in), .cb_in(cb_in), .cr_in(cr_in),
    .line_vld(line_vld), .cfg_fmt411(cfg_fmt411), .cfg_c_twos(cfg_c_twos),
    .cfg_y_lim(cfg_y_lim), .cfg_c_lim(cfg_c_lim), .cfg_blue_en(cfg_blue_en),
    .sync_lock(sync_lock), .cfg_out_en(cfg_out_en), .cfg_y_phase(cfg_y_phase),
    .cfg_c_phase(cfg_c_phase), .y_out(y_out), .c_out(c_out), .out_en(out_en)
  );

  typedef struct packed {
    logic       fmt411, twos, ylim, clim, blue_en, lock;
    logic [1:0] yph, cph;
    logic [7:0] npix, seed;
  } seg_t;

  localparam int NSEG = 15;
  localparam seg_t SEGS [NSEG] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd12,8'd3},   // R7 nominal 4:2:2
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd7, 8'd90},  // R1 odd length
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd10,8'd17},  // R2 4:1:1
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd8, 8'd200}, // R3 4:2:2 twos
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd8, 8'd55},  // R3 4:1:1 twos
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,2'd0,8'd12,8'd250}, // R4 limits
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,2'd0,8'd8, 8'd7},   // R4 4:1:1 limit
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,8'd6, 8'd11},  // R5 blue
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'd0,2'd0,8'd8, 8'd11},  // R5 blue+lim+twos
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd1,2'd2,8'd10,8'd60},  // R8
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,2'd3,8'd10,8'd130}, // R8
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'd3,2'd1,8'd10,8'd33},  // R8
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd6, 8'd77},  // R5 blue disabled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd3, 8'd140}, // R6 short line
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,8'd6, 8'd41}   // R6 restart
  };

  function automatic string seg_tag(int s);
    case (s)
      0: return "R7";  1: return "R1";  2: return "R2";  3, 4: return "R3";
      5, 6: return "R4";  7, 8, 12: return "R5";  9, 10, 11: return "R8";
      default: return "R6";
    endcase
  endfunction

  int checks = 0, errors = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference model state
  logic [7:0] exp_y [1024];
  logic [7:0] exp_c [1024];
  bit         exp_v [1024];
  int         exp_s [1024];
  int         m = 0;
  int         cur_seg = 0;
  bit         m_prev_lv = 0;
  int         m_cnt = 0;
  logic [7:0] m_hcb = 0, m_hcr = 0;

  function automatic int lat_of(logic [1:0] c);
    if (c == 2'd1) return 1;
    if (c == 2'd3) return 3;
    if (c == 2'd2) return 4;
    return 2;
  endfunction

  function automatic logic [7:0] lim(logic [7:0] v, int lo, int hi, bit en);
    if (!en) return v;
    if (int'(v) < lo) return 8'(lo);
    if (int'(v) > hi) return 8'(hi);
    return v;
  endfunction

  task automatic drive_pix(bit lv, logic [7:0] y, logic [7:0] cb, logic [7:0] cr);
    seg_t sg;
    int idx, ph;
    bit blue, cap;
    logic [7:0] yv, cbv, crv, ucb, ucr, cv;
    @(negedge clk);
    idx = m - lat_of(cfg_y_phase);
    if (idx >= 0 && exp_v[idx]) chk(seg_tag(exp_s[idx]), "y_out", int'(y_out), int'(exp_y[idx]));
    idx = m - lat_of(cfg_c_phase);
    if (idx >= 0 && exp_v[idx]) chk(seg_tag(exp_s[idx]), "c_out", int'(c_out), int'(exp_c[idx]));
    sg = SEGS[cur_seg];
    cfg_fmt411 = sg.fmt411; cfg_c_twos = sg.twos; cfg_y_lim = sg.ylim;
    cfg_c_lim = sg.clim; cfg_blue_en = sg.blue_en; sync_lock = sg.lock;
    cfg_y_phase = sg.yph; cfg_c_phase = sg.cph;
    line_vld = lv; luma_in = y; cb_in = cb; cr_in = cr;
    blue = sg.blue_en && !sg.lock;
    yv  = lim(blue ? 8'd41  : y,  16, 235, sg.ylim);
    cbv = lim(blue ? 8'd240 : cb, 16, 224, sg.clim);
    crv = lim(blue ? 8'd110 : cr, 16, 224, sg.clim);
    if (sg.twos) begin cbv = cbv ^ 8'h80; crv = crv ^ 8'h80; end
    ph = (lv && !m_prev_lv) ? 0 : m_cnt;
    cap = sg.fmt411 ? (ph == 0) : (ph % 2 == 0);
    ucb = cap ? cbv : m_hcb;
    ucr = cap ? crv : m_hcr;
    if (sg.fmt411) begin
      cv = 8'h00;
      cv[7:6] = 2'((ucb >> (6 - 2*ph)) & 8'h03);
      cv[5:4] = 2'((ucr >> (6 - 2*ph)) & 8'h03);
    end else begin
      cv = (ph % 2 == 1) ? ucr : ucb;
    end
    if (cap) begin m_hcb = cbv; m_hcr = crv; end
    if (lv) m_cnt = (ph + 1) % 4;
    m_prev_lv = lv;
    exp_y[m] = yv; exp_c[m] = cv; exp_v[m] = lv; exp_s[m] = cur_seg;
    m++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "y_out after reset", int'(y_out), 0);
    chk("R10", "c_out after reset", int'(c_out), 0);

    for (int s = 0; s < NSEG; s++) begin
      cur_seg = s;
      drive_pix(1'b0, 8'd0, 8'd128, 8'd128);
      drive_pix(1'b0, 8'd0, 8'd128, 8'd128);
      for (int k = 0; k < int'(SEGS[s].npix); k++)
        drive_pix(1'b1, 8'(int'(SEGS[s].seed) + 29*k),
                  8'(int'(SEGS[s].seed)*5 + 71*k),
                  8'(200 - 43*k + int'(SEGS[s].seed)));
    end
    for (int k = 0; k < 6; k++) drive_pix(1'b0, 8'd0, 8'd128, 8'd128);

    @(negedge clk);
    cfg_out_en = 1'b0;
    #1 chk("R9", "out_en low", int'(out_en), 0);
    @(negedge clk);
    cfg_out_en = 1'b1;
    #1 chk("R9", "out_en high", int'(out_en), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule